// File: doc/BRIEF.md
# Power Management Control Register

A 16-bit power control register for a small processor core. Software writes it to stop the core clock, to move the core onto a slow internal oscillator clock, to ask for powerdown of the crystal or small-signal clock input, and to switch off two serial ports, a host parallel interface and a timer. The core clock output is the selected source passed through a glitch-free gate. Once the core clock is stopped, software cannot restart it. Only an external interrupt whose wake enable bit is set clears the clock-stop bit, and that restarts the clock.

The register and the interrupt synchronizers run on the free-running main clock. A wake can therefore be seen while the core clock is stopped. Source selection uses a two-flop handshake mux. The gate uses a latch that can only change while the selected clock is low. As a result, no pulse is ever cut short.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After reset the register reads 0x0000, every enable output is low, and `clk_core` runs from `clk_main`.
- R2: A write with `wr_en` high stores the writable bits on the next `clk_main` rising edge. `rd_data` then returns the stored value, including any clear made by an interrupt.
- R3: Bits 11, 9, 8 and 3 to 0 are reserved. They always read 0, whatever value is written.
- R4: Bit 15 drives `xtal_pwrdn`. Bits 7, 6, 5 and 4 drive `dis_ser1`, `dis_ser2`, `dis_host` and `dis_timer` respectively.
- R5: Bit 13 set to 1 stops the core clock. After the edge that stores the bit, `clk_core` has no further rising edge while the bit stays set.
- R6: While bit 12 is 1, a high level on `irq0` clears bit 13 on the third `clk_main` rising edge after `irq0` rises. The clock then resumes.
- R7: While bit 10 is 1, a high level on `irq1` clears bit 13 with the same latency as R6.
- R8: An interrupt whose wake enable bit is 0 leaves bit 13 set, and the core clock stays stopped.
- R9: A wake clear and a software write in the same cycle store the written value with bit 13 forced to 0.
- R10: Bit 14 set to 1 makes `clk_core` follow `clk_slow`. Bit 14 set to 0 returns `clk_core` to `clk_main`.
- R11: `clk_core` never produces a high or low phase shorter than half a period of the faster source. This holds across source switches and across stopping and restarting the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Free-running main clock; clocks the register |
| clk_slow | input | 1 | Slow internal oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Current register value |
| irq0 | input | 1 | Interrupt 0, asynchronous |
| irq1 | input | 1 | Interrupt 1, asynchronous |
| clk_core | output | 1 | Gated, selected core clock |
| xtal_pwrdn | output | 1 | Powerdown request for the small-signal clock input |
| dis_ser1 | output | 1 | Serial port 1 disable |
| dis_ser2 | output | 1 | Serial port 2 disable |
| dis_host | output | 1 | Host parallel interface disable |
| dis_timer | output | 1 | Timer disable |

## Verification
The bench times the wake path to the exact edge. A design with one synchronizer stage too few or too many clears the stop bit a cycle early or late. It also checks that an interrupt whose enable bit is clear never restarts the clock. A design that ignores the enable would wake on any interrupt. It writes a stop request in the same cycle as a wake. If the write had priority, the core would stay frozen. It also measures every `clk_core` phase while sources switch and the gate toggles, so a combinational mux or gate would show runt pulses.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
// Package: field positions, write mask and shared sizes of the power
// control register. Assumes a 16-bit register with two wake interrupts.
package pwr_pkg;
    localparam int REG_W   = 16;
    localparam int N_IRQ   = 2;

    localparam int B_XTAL  = 15;   // small-signal input powerdown
    localparam int B_SLOW  = 14;   // select slow oscillator
    localparam int B_STOP  = 13;   // stop core clock
    localparam int B_WAKE0 = 12;   // irq0 wake enable
    localparam int B_WAKE1 = 10;   // irq1 wake enable
    localparam int B_SER1  = 7;
    localparam int B_SER2  = 6;
    localparam int B_HOST  = 5;
    localparam int B_TIMER = 4;

    localparam logic [REG_W-1:0] WR_MASK = 16'hF4F0;

    typedef int wake_pos_t [N_IRQ];
    localparam wake_pos_t WAKE_POS = '{B_WAKE0, B_WAKE1};
endpackage

// File: rtl/pwr_wake_sync.sv
`timescale 1ns/1ps
// Synchronizes asynchronous interrupt levels into the free-running clock
// domain. Assumes interrupts are held high for longer than STAGES cycles.
module pwr_wake_sync #(
    parameter int N_IRQ  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_async,
    output logic [N_IRQ-1:0] irq_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
        logic [STAGES-1:0] shreg;

        // Shift the interrupt level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[STAGES-2:0], irq_async[g]};
            end
        end

        assign irq_sync[g] = shreg[LAST];
    end
endmodule

// File: rtl/pwr_cfg_reg.sv
`timescale 1ns/1ps
// Holds the power control register. Masks reserved bits on write and
// clears the stop bit when an enabled synchronized interrupt is seen.
// The wake clear takes priority over a simultaneous write.
module pwr_cfg_reg
    import pwr_pkg::*;
#(
    parameter int N = N_IRQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [N-1:0]     irq_sync,
    output logic [REG_W-1:0] cfg_q,
    output logic             wake
);
    logic [N-1:0]     wake_vec;
    logic [REG_W-1:0] cfg_d;

    for (genvar g = 0; g < N; g++) begin : g_wake
        assign wake_vec[g] = irq_sync[g] & cfg_q[WAKE_POS[g]];
    end

    assign wake = |wake_vec;

    // Next register value: write first, then the wake clear overrides.
    always_comb begin
        cfg_d = wr_en ? (wr_data & WR_MASK) : cfg_q;
        if (wake) begin
            cfg_d[B_STOP] = 1'b0;
        end
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/pwr_clk_mux.sv
`timescale 1ns/1ps
// Glitch-free two-source clock mux. Each side enables itself only after
// the other side has dropped, and changes its enable on its own falling
// edge. Assumes reset is held for several periods of both clocks.
module pwr_clk_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_b,
    output logic clk_out,
    output logic act_a,
    output logic act_b
);
    logic a_q1, a_q2, b_q1, b_q2;

    // Side A request, sampled on clk_a rising edge.
    always_ff @(posedge clk_a) begin
        if (!rst_n) a_q1 <= 1'b1;
        else        a_q1 <= ~sel_b & ~b_q2;
    end

    // Side A enable, updated while clk_a goes low.
    always_ff @(negedge clk_a) begin
        if (!rst_n) a_q2 <= 1'b1;
        else        a_q2 <= a_q1;
    end

    // Side B request, sampled on clk_b rising edge.
    always_ff @(posedge clk_b) begin
        if (!rst_n) b_q1 <= 1'b0;
        else        b_q1 <= sel_b & ~a_q2;
    end

    // Side B enable, updated while clk_b goes low.
    always_ff @(negedge clk_b) begin
        if (!rst_n) b_q2 <= 1'b0;
        else        b_q2 <= b_q1;
    end

    assign clk_out = (clk_a & a_q2) | (clk_b & b_q2);
    assign act_a   = a_q2;
    assign act_b   = b_q2;
endmodule

// File: rtl/pwr_clk_gate.sv
`timescale 1ns/1ps
// Latch-based clock gate: the enable passes only while the clock is low,
// so the output is never cut mid-pulse.
module pwr_clk_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    // Transparent-low enable latch.
    always_latch begin
        if (!clk_in) en_lat = en;
    end

    assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/pwr_ctl_reg.sv
`timescale 1ns/1ps
// Top of the power control register. The register and the interrupt
// synchronizers run on clk_main, which must be free running. The core
// clock is the selected source passed through the glitch-free gate.
module pwr_ctl_reg
    import pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_main,
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq0,
    input  logic             irq1,
    output logic             clk_core,
    output logic             xtal_pwrdn,
    output logic             dis_ser1,
    output logic             dis_ser2,
    output logic             dis_host,
    output logic             dis_timer
);
    logic [N_IRQ-1:0] irq_sync;
    logic [REG_W-1:0] cfg_q;
    logic             wake;
    logic             clk_sel;
    logic             act_main, act_slow;

    pwr_wake_sync #(.N_IRQ(N_IRQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk_main),
        .rst_n     (rst_n),
        .irq_async ({irq1, irq0}),
        .irq_sync  (irq_sync)
    );

    pwr_cfg_reg #(.N(N_IRQ)) u_reg (
        .clk      (clk_main),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .irq_sync (irq_sync),
        .cfg_q    (cfg_q),
        .wake     (wake)
    );

    pwr_clk_mux u_mux (
        .clk_a   (clk_main),
        .clk_b   (clk_slow),
        .rst_n   (rst_n),
        .sel_b   (cfg_q[B_SLOW]),
        .clk_out (clk_sel),
        .act_a   (act_main),
        .act_b   (act_slow)
    );

    pwr_clk_gate u_gate (
        .clk_in  (clk_sel),
        .en      (~cfg_q[B_STOP]),
        .clk_out (clk_core)
    );

    assign rd_data    = cfg_q;
    assign xtal_pwrdn = cfg_q[B_XTAL];
    assign dis_ser1   = cfg_q[B_SER1];
    assign dis_ser2   = cfg_q[B_SER2];
    assign dis_host   = cfg_q[B_HOST];
    assign dis_timer  = cfg_q[B_TIMER];
endmodule

// File: rtl/pwr_ctl_chk.sv
`timescale 1ns/1ps
// Assertion checker for pwr_ctl_reg, attached by bind.
module pwr_ctl_chk
    import pwr_pkg::*;
(
    input logic             clk_main,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [N_IRQ-1:0] irq_sync,
    input logic             act_main,
    input logic             act_slow
);
    logic wake_any;
    assign wake_any = (irq_sync[0] & rd_data[B_WAKE0]) |
                      (irq_sync[1] & rd_data[B_WAKE1]);

    p_reserved_zero_r3: assert property (@(posedge clk_main) disable iff (!rst_n)
        (rd_data & ~WR_MASK) == '0);

    p_write_store_r2: assert property (@(posedge clk_main) disable iff (!rst_n)
        (wr_en && !wake_any) |=> rd_data == ($past(wr_data) & WR_MASK));

    p_hold_r2: assert property (@(posedge clk_main) disable iff (!rst_n)
        (!wr_en && !wake_any) |=> $stable(rd_data));

    p_wake0_r6: assert property (@(posedge clk_main) disable iff (!rst_n)
        (irq_sync[0] && rd_data[B_WAKE0]) |=> !rd_data[B_STOP]);

    p_wake1_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
        (irq_sync[1] && rd_data[B_WAKE1]) |=> !rd_data[B_STOP]);

    p_irq_wins_r9: assert property (@(posedge clk_main) disable iff (!rst_n)
        (wr_en && wake_any) |=> (rd_data == ($past(wr_data) & WR_MASK & ~(16'h1 << B_STOP))));

    p_mux_exclusive_r11: assert property (@(posedge clk_main) disable iff (!rst_n)
        $onehot0({act_main, act_slow}));
endmodule

bind pwr_ctl_reg pwr_ctl_chk u_chk (
    .clk_main (clk_main),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq_sync (irq_sync),
    .act_main (act_main),
    .act_slow (act_slow)
);

// File: tb/test_pwr_ctl_reg.sv
`timescale 1ns/1ps
module test_pwr_ctl_reg;
    localparam logic [15:0] MASK = 16'hF4F0;

    logic        clk_main = 1'b0, clk_slow = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, irq0 = 1'b0, irq1 = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        clk_core, xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer;

    int total = 0, bad = 0, edges = 0, runts = 0;
    bit done = 0;
    realtime t_r = 0.0, t_f = 0.0;

    always #2  clk_main = ~clk_main;
    always #13 clk_slow = ~clk_slow;

    pwr_ctl_reg i_pwr_ctl_reg (
        .clk_main(clk_main), .clk_slow(clk_slow), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq0(irq0), .irq1(irq1), .clk_core(clk_core),
        .xtal_pwrdn(xtal_pwrdn), .dis_ser1(dis_ser1), .dis_ser2(dis_ser2),
        .dis_host(dis_host), .dis_timer(dis_timer)
    );

    // Edge counter and phase-width monitor on the core clock (R11).
    always @(posedge clk_core) begin
        edges++;
        if (rst_n && t_f > 0.0 && ($realtime - t_f) < 1.9) runts++;
        t_r = $realtime;
    end
    always @(negedge clk_core) begin
        if (rst_n && t_r > 0.0 && ($realtime - t_r) < 1.9) runts++;
        t_f = $realtime;
    end

    function automatic logic [15:0] exp_wake(logic [15:0] v, logic i0, logic i1);
        if ((i0 && v[12]) || (i1 && v[10])) v[13] = 1'b0;
        return v;
    endfunction

    function automatic logic [4:0] exp_outs(logic [15:0] v);
        return {v[15], v[7], v[6], v[5], v[4]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_main);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk_main);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e0;
        logic [15:0] d, e;
        process::self().srandom(32'd1234);
        cyc(20);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        chk(rd_data == 16'h0, "R1", rd_data, 16'h0);
        chk({xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer} == 5'b0, "R1",
            {xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer}, 0);
        e0 = edges; cyc(10);
        chk(edges - e0 == 10, "R1", edges - e0, 10);

        // R3: reserved bits read zero
        wr(16'hFFFF);
        chk(rd_data == 16'hF4F0, "R3", rd_data, 16'hF4F0);
        wr(16'h0B0F);
        chk(rd_data == 16'h0000, "R3", rd_data, 16'h0);
        // R4: output mapping
        wr(16'h80A0);
        chk({xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer} == 5'b11010, "R4",
            {xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer}, 5'b11010);
        wr(16'h0);
        cyc(10);

        // R5: stop bit halts the core clock
        wr(16'h2000);
        e0 = edges; cyc(20);
        chk(edges == e0, "R5", edges - e0, 0);
        // R8: interrupts without enable do nothing
        irq0 = 1'b1; irq1 = 1'b1;
        cyc(8);
        chk(rd_data[13] == 1'b1, "R8", rd_data, 16'h2000);
        chk(edges == e0, "R8", edges - e0, 0);
        irq0 = 1'b0; irq1 = 1'b0;
        cyc(4);

        // R6: irq0 wake, exact latency
        wr(16'h3000);
        cyc(2);
        irq0 = 1'b1;
        cyc(2);
        chk(rd_data[13] == 1'b1, "R6", rd_data, 16'h3000);
        cyc(1);
        chk(rd_data == 16'h1000, "R6", rd_data, 16'h1000);
        e0 = edges; cyc(10);
        chk(edges - e0 >= 9, "R6", edges - e0, 10);
        irq0 = 1'b0;
        cyc(4);

        // R7: irq1 wake, exact latency
        wr(16'h2400);
        cyc(2);
        irq1 = 1'b1;
        cyc(2);
        chk(rd_data[13] == 1'b1, "R7", rd_data, 16'h2400);
        cyc(1);
        chk(rd_data == 16'h0400, "R7", rd_data, 16'h0400);
        irq1 = 1'b0;
        cyc(4);

        // R9: wake clear beats a simultaneous stop write
        wr(16'h1000);
        irq0 = 1'b1;
        cyc(4);
        wr(16'h30F0);
        chk(rd_data == 16'h10F0, "R9", rd_data, 16'h10F0);
        irq0 = 1'b0;
        cyc(4);

        // R10: slow source selection and return
        wr(16'h4000);
        cyc(30);
        e0 = edges; cyc(65);
        chk(edges - e0 >= 9 && edges - e0 <= 11, "R10", edges - e0, 10);
        wr(16'h0000);
        cyc(30);
        e0 = edges; cyc(40);
        chk(edges - e0 >= 39 && edges - e0 <= 41, "R10", edges - e0, 40);

        // Random: writes, then held interrupt levels (R2, R4, R6/R7/R8)
        for (int k = 0; k < 200; k++) begin
            logic i0, i1;
            d = 16'($urandom());
            if (k < 8) d = (k % 2 == 0) ? 16'hFFFF : 16'h0000;
            wr(d);
            e = d & MASK;
            chk(rd_data == e, "R2", rd_data, e);
            chk({xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer} == exp_outs(e), "R4",
                {xtal_pwrdn, dis_ser1, dis_ser2, dis_host, dis_timer}, exp_outs(e));
            i0 = 1'($urandom()); i1 = 1'($urandom());
            irq0 = i0; irq1 = i1;
            cyc(5);
            chk(rd_data == exp_wake(e, i0, i1), "R6/R7/R8", rd_data, exp_wake(e, i0, i1));
            irq0 = 1'b0; irq1 = 1'b0;
            cyc(3 + int'($urandom_range(0, 6)));
        end
        wr(16'h0000);
        cyc(30);

        // R11: no runt phases observed anywhere in the run
        chk(runts == 0, "R11", runts, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule